// File: doc/BRIEF.md
# Chunked RAM Overlay Enable Controller

This block sits between a CPU's memory bus and a 64 KB RAM that is mapped across the whole 16-bit address space. The space is cut into eight 8 KB chunks, and the top three address bits pick the chunk. Each chunk has one enable bit. When the bit is set, the overlay RAM claims every access in that chunk. When the bit is clear, the block leaves the access to the native bus, so ROM, memory-mapped devices or an external expansion answer instead.

The enable bits are set, cleared and read back through a serial bit-addressable control port. Each write carries a bit index and a value. The RAM address is the CPU address itself, with no translation. A disabled chunk gets no RAM write strobe, so the RAM keeps its contents and the same data is there again once the chunk is re-enabled.

After reset only the four chunks that make up a standard 32 KB expansion are enabled: 0x2000, 0xA000, 0xC000 and 0xE000. Clearing those four bits lets an external 32 KB expansion answer in the same range, which gives software two 32 KB banks to switch between.

Top module: `ovl_ctrl`

## Requirements
- R1: The chunk number is `mem_addr[15:13]`. While `mem_req`=1 and that chunk's enable bit is 1, `ram_cs`=1 and `pass_thru`=0 in the same cycle.
- R2: While `mem_req`=1 and that chunk's enable bit is 0, `pass_thru`=1 and `ram_cs`=0 in the same cycle.
- R3: While `mem_req`=0, `ram_cs`, `ram_we` and `pass_thru` are all 0, whatever the address and `mem_we` are.
- R4: `ram_addr` always equals `mem_addr`.
- R5: `ram_we`=1 exactly when `mem_req`=1, `mem_we`=1 (1 means write) and the chunk is enabled. A write to a disabled chunk never reaches the RAM.
- R6: After reset the enable mask is 8'b1110_0010, with bit n belonging to chunk n. Chunks 1, 5, 6 and 7 start enabled.
- R7: With `bit_wr`=1 and `bit_idx` in the range 0..7, the enable bit of chunk `bit_idx` takes the value `bit_val` at the clock edge. The change shows from the next cycle on, and the other bits keep their values.
- R8: `bit_rd` shows the enable bit of chunk `bit_idx` in the same cycle, for `bit_idx` in the range 0..7.
- R9: Port indices 8..15 are reserved. They read back as 0, and writing to them changes no enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mem_req | input | 1 | Memory access strobe |
| mem_we | input | 1 | 1 = write, 0 = read |
| mem_addr | input | 16 | CPU byte address |
| bit_wr | input | 1 | Control-port bit write strobe |
| bit_idx | input | 4 | Control-port bit index |
| bit_val | input | 1 | Value to write at `bit_idx` |
| bit_rd | output | 1 | Readback of the bit at `bit_idx` |
| ram_cs | output | 1 | Overlay RAM chip select |
| ram_we | output | 1 | Overlay RAM write strobe |
| ram_addr | output | 16 | Overlay RAM address |
| pass_thru | output | 1 | Access is left to the native bus |

## Verification
The bench builds the block with its default parameters: eight chunks, a 4-bit control-port index and the 0xE2 reset mask. With these values every one of the 256 enable masks can be loaded through the port and then probed with reads and writes in all eight chunks. The same build lets the bench sweep all sixteen port indices, so both reserved indices and live ones are covered. It also places probes at the low and high edges of each chunk and checks when a port write first takes effect.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int OVL_ADDR_W     = 16;
  localparam int OVL_CHUNK_W    = 3;
  localparam int OVL_PORT_W     = 4;
  localparam int OVL_N_CHUNKS   = 1 << OVL_CHUNK_W;
  localparam logic [OVL_N_CHUNKS-1:0] OVL_RESET_MASK = 8'b1110_0010;
endpackage

// File: rtl/ovl_rst_sync.sv
module ovl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_nxt;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ovl_mask_regs.sv
module ovl_mask_regs #(
  parameter int N      = 8,
  parameter int PORT_W = 4,
  parameter logic [N-1:0] RESET_MASK = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [PORT_W-1:0] idx,
  input  logic          val,
  output logic [N-1:0]  mask,
  output logic          rd
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic idx_live;
  assign idx_live = (32'(idx) < N);

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic en_q;
    logic en_nxt;
    logic hit;

    assign hit = wr && (idx == PORT_W'(g));

    always_comb begin
      en_nxt = hit ? val : en_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   en_q <= RESET_MASK[g];
      else if (hit) en_q <= en_nxt;
    end

    assign mask[g] = en_q;
  end

  always_comb begin
    rd = idx_live ? mask[idx[IDX_W-1:0]] : 1'b0;
  end
endmodule

// File: rtl/ovl_decode.sv
module ovl_decode #(
  parameter int ADDR_W  = 16,
  parameter int CHUNK_W = 3,
  localparam int N      = 1 << CHUNK_W
) (
  input  logic              mem_req,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [N-1:0]      mask,
  output logic              ram_cs,
  output logic              ram_we,
  output logic              pass_thru
);
  logic [CHUNK_W-1:0] chunk;
  logic               chunk_en;

  always_comb begin
    chunk     = mem_addr[ADDR_W-1 -: CHUNK_W];
    chunk_en  = mask[chunk];
    ram_cs    = mem_req &  chunk_en;
    ram_we    = mem_req &  chunk_en & mem_we;
    pass_thru = mem_req & ~chunk_en;
  end
endmodule

// File: rtl/ovl_ctrl.sv
module ovl_ctrl
  import ovl_pkg::*;
#(
  parameter int ADDR_W  = OVL_ADDR_W,
  parameter int CHUNK_W = OVL_CHUNK_W,
  parameter int PORT_W  = OVL_PORT_W,
  parameter logic [(1<<CHUNK_W)-1:0] RESET_MASK = OVL_RESET_MASK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_req,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              bit_wr,
  input  logic [PORT_W-1:0] bit_idx,
  input  logic              bit_val,
  output logic              bit_rd,
  output logic              ram_cs,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              pass_thru
);
  localparam int N = 1 << CHUNK_W;

  logic         rst_sync_n;
  logic [N-1:0] en_mask;

  ovl_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ovl_mask_regs #(.N(N), .PORT_W(PORT_W), .RESET_MASK(RESET_MASK)) u_mask (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr    (bit_wr),
    .idx   (bit_idx),
    .val   (bit_val),
    .mask  (en_mask),
    .rd    (bit_rd)
  );

  ovl_decode #(.ADDR_W(ADDR_W), .CHUNK_W(CHUNK_W)) u_dec (
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mask      (en_mask),
    .ram_cs    (ram_cs),
    .ram_we    (ram_we),
    .pass_thru (pass_thru)
  );

  // identity mapping: the overlay RAM sees the CPU address unchanged
  assign ram_addr = mem_addr;
endmodule

// File: rtl/ovl_ctrl_chk.sv
module ovl_ctrl_chk #(
  parameter int ADDR_W  = 16,
  parameter int CHUNK_W = 3,
  parameter int PORT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              bit_wr,
  input logic [PORT_W-1:0] bit_idx,
  input logic              bit_val,
  input logic              bit_rd,
  input logic              ram_cs,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              pass_thru
);
  localparam int N = 1 << CHUNK_W;

  // R1 R2: a strobed access is claimed by exactly one side
  p_one_owner_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (ram_cs ^ pass_thru));

  // R3: idle bus drives nothing
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |-> (!ram_cs && !ram_we && !pass_thru));

  // R5: no RAM write without the RAM selected and a write cycle
  p_we_needs_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_cs && mem_we));

  // R1 R8: decode agrees with the readback of the same chunk's bit
  p_cs_matches_rd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && (32'(mem_addr[ADDR_W-1 -: CHUNK_W]) == 32'(bit_idx)))
      |-> (ram_cs == bit_rd));

  // R7: a port write shows on the readback one cycle later
  p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_wr && (32'(bit_idx) < N)) |=>
      ((bit_idx != $past(bit_idx)) || (bit_rd == $past(bit_val))));

  // R9: reserved indices read as zero
  p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(bit_idx) >= N) |-> !bit_rd);
endmodule

bind ovl_ctrl ovl_ctrl_chk #(
  .ADDR_W  (ADDR_W),
  .CHUNK_W (CHUNK_W),
  .PORT_W  (PORT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .bit_wr    (bit_wr),
  .bit_idx   (bit_idx),
  .bit_val   (bit_val),
  .bit_rd    (bit_rd),
  .ram_cs    (ram_cs),
  .ram_we    (ram_we),
  .ram_addr  (ram_addr),
  .pass_thru (pass_thru)
);

// File: tb/ovl_ctrl_tb.sv
module ovl_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr;
  logic        bit_wr, bit_val;
  logic [3:0]  bit_idx;
  logic        bit_rd, ram_cs, ram_we, pass_thru;
  logic [15:0] ram_addr;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  ovl_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .bit_wr(bit_wr), .bit_idx(bit_idx),
    .bit_val(bit_val), .bit_rd(bit_rd), .ram_cs(ram_cs), .ram_we(ram_we),
    .ram_addr(ram_addr), .pass_thru(pass_thru)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic port_write(input logic [3:0] idx, input logic val);
    @(negedge clk);
    bit_wr = 1'b1; bit_idx = idx; bit_val = val;
    @(negedge clk);
    bit_wr = 1'b0;
  endtask

  // drive one access, then check every decode output against the expected mask
  task automatic probe(input logic [7:0] m, input logic req, input logic we,
                       input logic [15:0] addr);
    logic en;
    @(negedge clk);
    mem_req = req; mem_we = we; mem_addr = addr; bit_idx = {1'b0, addr[15:13]};
    #2;
    en = m[addr[15:13]];
    chk("R1 ram_cs",    32'(ram_cs),    32'(req & en));
    chk("R2 pass_thru", 32'(pass_thru), 32'(req & ~en));
    chk("R5 ram_we",    32'(ram_we),    32'(req & en & we));
    chk("R4 ram_addr",  32'(ram_addr),  32'(addr));
    chk("R8 bit_rd",    32'(bit_rd),    32'(en));
    mem_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] cur;
    rst_n = 1'b0; mem_req = 1'b0; mem_we = 1'b0; mem_addr = '0;
    bit_wr = 1'b0; bit_idx = '0; bit_val = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R6: reset mask, probed at both edges of every chunk, reads and writes
    for (int c = 0; c < 8; c++) begin
      probe(8'hE2, 1'b1, 1'b0, {3'(c), 13'h0000});
      probe(8'hE2, 1'b1, 1'b1, {3'(c), 13'h1FFF});
      chk("R6 reset bit", 32'(bit_rd), 32'((8'hE2 >> c) & 1));
    end

    // R3: no strobe, nothing driven
    for (int c = 0; c < 8; c++) probe(8'hE2, 1'b0, 1'b1, {3'(c), 13'h0AAA});

    // R9: reserved indices read 0 and ignore writes
    for (int i = 8; i < 16; i++) port_write(4'(i), 1'b1);
    for (int i = 8; i < 16; i++) begin
      @(negedge clk); bit_idx = 4'(i); #2;
      chk("R9 reserved reads 0", 32'(bit_rd), 32'd0);
    end
    for (int c = 0; c < 8; c++) probe(8'hE2, 1'b1, 1'b0, {3'(c), 13'h0100});

    // R7: timing of a port write
    @(negedge clk);
    bit_wr = 1'b1; bit_idx = 4'd2; bit_val = 1'b1; #2;
    chk("R7 old value before edge", 32'(bit_rd), 32'd0);
    @(negedge clk);
    bit_wr = 1'b0; #2;
    chk("R7 new value after edge", 32'(bit_rd), 32'd1);
    cur = 8'hE6;
    for (int c = 0; c < 8; c++) probe(cur, 1'b1, 1'b1, {3'(c), 13'h1234});

    // R1 R2 R5 R7 R8: every mask, every chunk
    for (int m = 0; m < 256; m++) begin
      for (int b = 0; b < 8; b++) port_write(4'(b), m[b]);
      for (int c = 0; c < 8; c++)
        probe(8'(m), 1'b1, 1'((m + c) & 1), {3'(c), 13'((c * 797 + m * 31) & 13'h1FFF)});
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule